// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

A memory-mapped timer peripheral holding several independent down-counters. Each channel owns a control word, an interval value and a readable live count. A channel may run periodically, restarting from its interval each time it runs out, or once, stopping after the first expiry. Every expiry latches a per-channel status flag. A shared enable mask decides which flags drive the single interrupt line.

All counting advances only on clock cycles where the timer tick input is high. That input stands for the selected slow source clock. Software loads a channel by setting enable and the reload bit together, and clears a flag by writing a one to its status bit. A channel whose enable is cleared does not stop at once: it still counts for a fixed number of further ticks, which models the crossing into the slow timer domain. The bus is a plain synchronous write port with a combinational read path.

Top module: `multi_interval_timer`

## Requirements
- R1: After reset every control, interval, count, enable-mask and status register reads zero and `irq` is low.
- R2: Register map: 0x00 holds the interrupt enable mask (bit n for channel n), 0x04 holds the status flags, and channel n sits at 0x10*(n+1) for control, +0x04 for interval and +0x08 for the current count. Any other offset reads zero.
- R3: Control bits: bit 0 enable, bit 1 reload, bits 3:2 source select (stored, read back), bits 6:4 prescale exponent, bit 7 one-shot when set. The reload bit clears itself once its load has been done.
- R4: On the first tick on which a channel is active with reload set, the count takes the interval value, and no decrement happens on that tick.
- R5: With prescale exponent N, an active channel steps its count once every 2^N ticks, counted from the last load.
- R6: A step takes the count from c to c-1. A step from 1 to 0 is an expiry and sets the channel's status bit. A step taken at 0 reloads the interval, so a periodic channel keeps running, and an all-ones interval gives a falling value.
- R7: In one-shot mode an expiry clears the enable bit, and the count then stays at 0.
- R8: After enable is cleared on a running channel, it takes exactly 2 more counting ticks and then holds its count.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. An expiry in the same cycle wins over the clear.
- R10: `irq` is high exactly when some channel has both its status bit and its enable-mask bit set. Status is set regardless of the mask.
- R11: In cycles with `tick_en` low no count changes.
- R12: Writes to a current-count offset have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick qualifier standing in for the source clock |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR over channels of status AND enable |

## Verification
The bench builds the block with its defaults: two channels, 32-bit counters, an 8-bit offset space and a two-tick stop delay. Two channels are enough to show that the shared mask and status bits act per channel, and that an offset one channel past the last one decodes to zero. Full-width counters let an all-ones interval be loaded and seen falling. A random phase with small intervals makes expiries, reloads, one-shot stops and status clears land on the same cycles as bus writes, while a behavioural model is compared on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int PRE_W        = 3;
   localparam int CTRL_W       = 8;
   localparam int OFS_IE       = 'h00;
   localparam int OFS_ST       = 'h04;
   localparam int CH_BASE      = 'h10;
   localparam int CH_STRIDE    = 'h10;
   localparam int SUB_CTRL     = 'h0;
   localparam int SUB_IVL      = 'h4;
   localparam int SUB_CNT      = 'h8;

   typedef struct packed {
      logic             oneshot;
      logic [PRE_W-1:0] pre;
      logic [1:0]       src;
      logic             reload;
      logic             en;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SEL_W-1:0] sel,
   output logic             step
);
   localparam int PC_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("tmr_prescaler: SEL_W out of range");
   end

   logic [PC_W-1:0] pcnt_q;
   logic [PC_W-1:0] mask;

   always_comb begin
      mask = PC_W'((32'd1 << sel) - 32'd1);
      step = adv && (pcnt_q >= mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         pcnt_q <= '0;
      end else if (adv) begin
         pcnt_q <= step ? '0 : pcnt_q + 1'b1;
      end
   end

   assert_step_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && sel != '0) |=> !step);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int GRACE_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctrl_we,
   input  tmr_ctrl_t        ctrl_wdata,
   input  logic             ivl_we,
   input  logic [CNT_W-1:0] ivl_wdata,
   output tmr_ctrl_t        ctrl_q,
   output logic [CNT_W-1:0] ivl_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire
);
   localparam int G_W = $clog2(GRACE_TICKS + 1);

   if (GRACE_TICKS < 1) begin : g_bad_grace
      $error("tmr_channel: GRACE_TICKS must be at least 1");
   end

   logic [G_W-1:0] grace_q;
   logic           active, do_load, do_adv, step;

   always_comb begin
      active  = ctrl_q.en || (grace_q != '0);
      do_load = tick && active && ctrl_q.reload;
      do_adv  = tick && active && !ctrl_q.reload;
      expire  = step && (cnt_q == CNT_W'(1));
   end

   tmr_prescaler #(.SEL_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_load),
      .adv   (do_adv),
      .sel   (ctrl_q.pre),
      .step  (step)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ivl_q   <= '0;
         cnt_q   <= '0;
         grace_q <= '0;
      end else begin
         if (ivl_we) ivl_q <= ivl_wdata;

         if (do_load)   cnt_q <= ivl_q;
         else if (step) cnt_q <= (cnt_q == '0) ? ivl_q : cnt_q - 1'b1;

         if (ctrl_q.en)                       grace_q <= G_W'(GRACE_TICKS);
         else if (tick && grace_q != '0)      grace_q <= grace_q - 1'b1;
         if (expire && ctrl_q.oneshot)        grace_q <= '0;

         if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
         end else begin
            if (do_load)                      ctrl_q.reload <= 1'b0;
            if (expire && ctrl_q.oneshot)     ctrl_q.en     <= 1'b0;
         end
      end
   end

   assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      do_load |=> (cnt_q == $past(ivl_q)));

   assert_reload_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_load && !ctrl_we) |=> !ctrl_q.reload);

   assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q.oneshot && !ctrl_we) |=> (!ctrl_q.en && grace_q == '0));

   assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

   assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && grace_q == '0) |=> $stable(cnt_q));

endmodule

// File: rtl/multi_interval_timer.sv
module multi_interval_timer
   import tmr_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int CNT_W       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int GRACE_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int SPAN = CH_BASE + CH_STRIDE * NUM_CH;
   localparam logic [ADDR_W-1:0] A_IE = ADDR_W'(OFS_IE);
   localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_ST);

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_nch
      $error("multi_interval_timer: NUM_CH out of range");
   end
   if (CNT_W < 2 || CNT_W > DATA_W || DATA_W < CTRL_W) begin : g_bad_w
      $error("multi_interval_timer: width parameters inconsistent");
   end
   if (SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("multi_interval_timer: ADDR_W too small for NUM_CH");
   end

   logic [NUM_CH-1:0] ie_q, st_q, expire, st_clr;
   tmr_ctrl_t         ctrl_rd [NUM_CH];
   logic [CNT_W-1:0]  ivl_rd  [NUM_CH];
   logic [CNT_W-1:0]  cnt_rd  [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CTRL);
      localparam logic [ADDR_W-1:0] A_IVL  = ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_IVL);

      tmr_channel #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick_en),
         .ctrl_we    (bus_wr && bus_addr == A_CTRL),
         .ctrl_wdata (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
         .ivl_we     (bus_wr && bus_addr == A_IVL),
         .ivl_wdata  (bus_wdata[CNT_W-1:0]),
         .ctrl_q     (ctrl_rd[i]),
         .ivl_q      (ivl_rd[i]),
         .cnt_q      (cnt_rd[i]),
         .expire     (expire[i])
      );

      assert_status_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
         expire[i] |=> st_q[i]);

      assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_ST && bus_wdata[i] && !expire[i]) |=> !st_q[i]);
   end

   always_comb begin
      st_clr = (bus_wr && bus_addr == A_ST) ? bus_wdata[NUM_CH-1:0] : '0;
      irq    = |(st_q & ie_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q <= '0;
         st_q <= '0;
      end else begin
         if (bus_wr && bus_addr == A_IE) ie_q <= bus_wdata[NUM_CH-1:0];
         st_q <= (st_q & ~st_clr) | expire;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_IE) bus_rdata = DATA_W'(ie_q);
      if (bus_addr == A_ST) bus_rdata = DATA_W'(st_q);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CTRL)) bus_rdata = DATA_W'(ctrl_rd[i]);
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_IVL))  bus_rdata = DATA_W'(ivl_rd[i]);
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CNT))  bus_rdata = DATA_W'(cnt_rd[i]);
      end
   end

   assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == '0) |-> !irq);

endmodule

// File: tb/multi_interval_timer_tb_top.sv
module multi_interval_timer_tb_top;
   localparam int NCH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   multi_interval_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference state
   bit          m_en [NCH], m_rl [NCH], m_os [NCH];
   int          m_src[NCH], m_pre[NCH], m_g[NCH], m_p[NCH];
   logic [31:0] m_ivl[NCH], m_cnt[NCH];
   int          m_ie, m_st;

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [7:0] a);
      int c;
      if (a == 8'h00) return 32'(m_ie);
      if (a == 8'h04) return 32'(m_st);
      if (a < 8'h10) return '0;
      c = int'(a >> 4) - 1;
      if (c >= NCH) return '0;
      case (a & 8'h0f)
         8'h0: return 32'({m_os[c], 3'(m_pre[c]), 2'(m_src[c]), m_rl[c], m_en[c]});
         8'h4: return m_ivl[c];
         8'h8: return m_cnt[c];
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ie = 0; m_st = 0;
         for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_rl[c] = 0; m_os[c] = 0; m_src[c] = 0; m_pre[c] = 0;
            m_g[c] = 0; m_p[c] = 0; m_ivl[c] = '0; m_cnt[c] = '0;
         end
      end else begin
         int xb;
         xb = 0;
         for (int c = 0; c < NCH; c++) begin
            bit act, ex, stp;
            logic [7:0] ca;
            ex = 0; stp = 0;
            act = m_en[c] || m_g[c] != 0;
            if (tick_en && act) begin
               if (m_rl[c]) begin
                  m_cnt[c] = m_ivl[c]; m_p[c] = 0; m_rl[c] = 0;
               end else begin
                  if (m_p[c] >= (1 << m_pre[c]) - 1) begin stp = 1; m_p[c] = 0; end
                  else m_p[c] = m_p[c] + 1;
                  if (stp) begin
                     if (m_cnt[c] == 0) m_cnt[c] = m_ivl[c];
                     else begin
                        if (m_cnt[c] == 1) ex = 1;
                        m_cnt[c] = m_cnt[c] - 1;
                     end
                  end
               end
            end
            if (m_en[c]) m_g[c] = 2;
            else if (tick_en && m_g[c] != 0) m_g[c] = m_g[c] - 1;
            if (ex && m_os[c]) begin m_en[c] = 0; m_g[c] = 0; end
            if (ex) xb = xb | (1 << c);
            ca = 8'(16 * (c + 1));
            if (bus_wr && bus_addr == ca) begin
               m_en[c]  = bus_wdata[0]; m_rl[c] = bus_wdata[1];
               m_src[c] = int'(bus_wdata[3:2]); m_pre[c] = int'(bus_wdata[6:4]);
               m_os[c]  = bus_wdata[7];
            end
            if (bus_wr && bus_addr == ca + 8'h4) m_ivl[c] = bus_wdata;
         end
         if (bus_wr && bus_addr == 8'h00) m_ie = int'(bus_wdata[NCH-1:0]);
         if (bus_wr && bus_addr == 8'h04) m_st = m_st & ~int'(bus_wdata[NCH-1:0]);
         m_st = m_st | xb;
      end
   end

   // every-clock comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         check("R10 irq", 32'(irq), 32'((m_st & m_ie) != 0));
         check("R2 readback", bus_rdata, m_read(bus_addr));
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic run(int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h10, v); check("R1 ctrl0", v, 32'h0);
      rd(8'h14, v); check("R1 ivl0", v, 32'h0);
      rd(8'h18, v); check("R1 cnt0", v, 32'h0);
      rd(8'h04, v); check("R1 status", v, 32'h0);
      rd(8'h00, v); check("R1 enable mask", v, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);

      // R2 unmapped offsets
      rd(8'h08, v); check("R2 gap 0x08", v, 32'h0);
      rd(8'h30, v); check("R2 past last channel", v, 32'h0);
      rd(8'h1c, v); check("R2 channel hole", v, 32'h0);

      // R3/R4/R6 periodic load and expiry
      wr(8'h14, 32'd5);
      wr(8'h10, 32'h07);
      rd(8'h10, v); check("R3 reload pending", v, 32'h07);
      run(1);
      rd(8'h18, v); check("R4 loaded", v, 32'd5);
      rd(8'h10, v); check("R3 reload self-clear", v, 32'h05);
      run(3);
      rd(8'h18, v); check("R4 count after 3 ticks", v, 32'd2);
      run(2);
      rd(8'h18, v); check("R6 reached zero", v, 32'd0);
      rd(8'h04, v); check("R6 status set", v, 32'h1);
      check("R10 masked irq low", 32'(irq), 32'h0);
      run(1);
      rd(8'h18, v); check("R6 periodic reload", v, 32'd5);

      // R10/R9 mask and write-one-to-clear
      wr(8'h00, 32'h1);
      rd(8'h00, v); check("R10 irq with mask", 32'(irq), 32'h1);
      wr(8'h04, 32'h0);
      rd(8'h04, v); check("R9 write zero keeps", v, 32'h1);
      wr(8'h04, 32'h1);
      rd(8'h04, v); check("R9 write one clears", v, 32'h0);
      check("R10 irq after clear", 32'(irq), 32'h0);

      // R11 no tick, no count
      repeat (10) @(negedge clk);
      rd(8'h18, v); check("R11 hold without tick", v, 32'd5);

      // R12 count offset is read-only
      wr(8'h18, 32'h123);
      rd(8'h18, v); check("R12 count write ignored", v, 32'd5);

      // R8 two-tick stop delay
      wr(8'h10, 32'h04);
      run(6);
      rd(8'h18, v); check("R8 stops after two ticks", v, 32'd3);

      // R7 one-shot
      wr(8'h14, 32'd3);
      wr(8'h10, 32'h87);
      run(8);
      rd(8'h18, v); check("R7 one-shot held at zero", v, 32'd0);
      rd(8'h10, v); check("R7 enable cleared", v, 32'h84);
      check("R10 irq one-shot", 32'(irq), 32'h1);
      wr(8'h04, 32'h1);

      // R5 prescaler on channel 1
      wr(8'h24, 32'd100);
      wr(8'h20, 32'h23);
      run(1);
      run(8);
      rd(8'h28, v); check("R5 divide by four", v, 32'd98);

      // R6 free-running falling value
      wr(8'h24, 32'hffff_ffff);
      wr(8'h20, 32'h07);
      run(4);
      rd(8'h28, v); check("R6 falling from all ones", v, 32'hffff_fffc);

      // random phase, model compared every clock
      for (int k = 0; k < 4000; k++) begin
         logic [7:0] al [10];
         al = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h08, 8'h30};
         @(negedge clk);
         tick_en   = ($urandom % 2) == 0;
         bus_addr  = al[$urandom % 10];
         bus_wr    = ($urandom % 5) == 0;
         bus_wdata = (bus_addr[3:0] == 4'h4) ? 32'($urandom % 8) :
                     (bus_addr[3:0] == 4'h0 && bus_addr != 8'h00) ? 32'($urandom % 256) & 32'h9f :
                     32'($urandom);
      end
      @(negedge clk);
      bus_wr = 1'b0; tick_en = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule